// File: doc/BRIEF.md
# SWD Link Connect and Identify Sequencer

This block takes a two-wire serial debug link from an unknown state to a state where the debug port answers. After a `start` pulse it owns the data line and drives three raw bit patterns: a run of high bits long enough to reset the line, the 16-bit protocol switch word 0xE79E sent least significant bit first, and a second run of high bits. It then drives a short stretch of low idle bits and hands the line to a transaction engine.

Through that engine's request interface the sequencer issues four transactions in a fixed order:

1. A debug-port read of the identification code.
2. A debug-port write of the select register, which picks the access port and its identifier bank.
3. A posted access-port read of the identifier register.
4. A debug-port read of the read buffer, which returns the identifier.

Each step starts only after the previous step receives an OK acknowledge. A WAIT acknowledge is retried a bounded number of times. Any other outcome stops the sequence with an error code that names the step and the cause. No target reset pin is used.

On success the `connected` flag rises. The identification code and the access port identifier stay in output registers until the next start.

Top module: `swdc_connect`

## Requirements
- R1: After reset, `busy`, `connected`, `failed`, `rawEn` and `reqValid` are 0, `errCode` is 0, and `idCode` and `apId` are 0.
- R2: A `start` pulse while idle makes `rawEn` high from the next cycle. The first RESET_BITS bits on `rawBit` (default 52, at least 50) are all 1.
- R3: The next 16 raw bits are the word 0xE79E, least significant bit first.
- R4: A second run of RESET_BITS ones follows, then IDLE_BITS (at least 2) zeros. In the cycle after the last zero, `rawEn` is 0 and `reqValid` is 1. The raw phase lasts exactly 2*RESET_BITS+16+IDLE_BITS cycles.
- R5: The requests, in order, are:
  - a DP read (`reqApNDp`=0, `reqRnW`=1) at `reqAddr`=0;
  - a DP write at `reqAddr`=2 with `reqWdata` = {apSel, 16'h0000, 8'hF0};
  - an AP read at `reqAddr`=3;
  - a DP read at `reqAddr`=3.

  Each request is held steady until `rspValid`.
- R6: When `rspValid` comes with ack 3'b010 (WAIT), `reqValid` drops for one cycle and the same request is issued again. This happens up to WAIT_RETRIES times per step, and the retry count restarts at each new step.
- R7: A WAIT that arrives after the retries are used up ends the run with `failed`=1 and `errCode` = {step, 2'd1}. Steps are numbered 1 to 4 in the order of R5 and occupy `errCode[4:2]`.
- R8: An ack other than 3'b001 (OK) and 3'b010 ends the run with `errCode` = {step, 2'd0}. After a failure, no further request is issued and `rawEn` stays 0.
- R9: An OK read response with `rspParityErr`=1 ends the run with `errCode` = {step, 2'd2}.
- R10: With CHECK_ID=1, an identification value different from EXPECT_ID ends the run with `errCode` = {1, 2'd3}. `rspParityErr` has no effect on the write step.
- R11: After the fourth step answers OK, `connected` is 1 and `failed` is 0. `idCode` holds the step 1 data and `apId` holds the step 4 data, and both stay until the next start. A start clears `connected`, `failed`, `errCode`, `idCode` and `apId` in the next cycle.
- R12: A `start` pulse while `busy` has no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one raw bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a connect sequence (ignored while busy) |
| apSel | input | 8 | Access port number placed in the select write |
| rawEn | output | 1 | Sequencer is driving the data line |
| rawBit | output | 1 | Raw bit value for the data line |
| reqValid | output | 1 | Transaction request to the engine |
| reqApNDp | output | 1 | 1 = access port, 0 = debug port |
| reqRnW | output | 1 | 1 = read, 0 = write |
| reqAddr | output | 2 | Register address bits [3:2] |
| reqWdata | output | 32 | Write data |
| rspValid | input | 1 | One-cycle response strobe from the engine |
| rspAck | input | 3 | Acknowledge value (OK 3'b001, WAIT 3'b010) |
| rspRdata | input | 32 | Read data |
| rspParityErr | input | 1 | Read data parity mismatch |
| busy | output | 1 | Sequence in progress |
| connected | output | 1 | Sequence completed successfully |
| failed | output | 1 | Sequence stopped on an error |
| errCode | output | 5 | {step[2:0], cause[1:0]} of the failure |
| idCode | output | 32 | Captured identification code |
| apId | output | 32 | Captured access port identifier |

## Verification
The assertions assume that the engine pulses `rspValid` for exactly one cycle, only while `reqValid` is high, and never twice for the same request. They also assume that `apSel` does not change during a run. The bench responder keeps to this contract. It answers only after it has seen `reqValid` on two consecutive sampling points, drops `rspValid` on the next one, and holds `apSel` fixed throughout. This keeps the request stability check meaningful, because every request waits at least one cycle before it is answered.

// File: rtl/swdc_pkg.sv
package swdc_pkg;

  typedef enum logic [1:0] {
    PAT_RESET  = 2'd0,
    PAT_SWITCH = 2'd1,
    PAT_IDLE   = 2'd2
  } patE;

  typedef enum logic [2:0] {
    STEP_NONE = 3'd0,
    STEP_ID   = 3'd1,
    STEP_SEL  = 3'd2,
    STEP_APRD = 3'd3,
    STEP_BUF  = 3'd4
  } stepE;

  localparam logic [2:0] ACK_OK   = 3'b001;
  localparam logic [2:0] ACK_WAIT = 3'b010;

  localparam logic [1:0] CAUSE_ACK    = 2'd0;
  localparam logic [1:0] CAUSE_WAIT   = 2'd1;
  localparam logic [1:0] CAUSE_PARITY = 2'd2;
  localparam logic [1:0] CAUSE_IDMISS = 2'd3;

  localparam logic [15:0] SWITCH_WORD = 16'hE79E;

  typedef struct packed {
    logic load;
    patE  pat;
    logic shift;
    logic clrRetry;
    logic incRetry;
    logic capId;
    logic capAp;
    logic clrCaps;
  } dpStrobeT;

endpackage

// File: rtl/swdc_datapath.sv
module swdc_datapath
  import swdc_pkg::*;
#(
  parameter int RESET_BITS   = 52,
  parameter int IDLE_BITS    = 2,
  parameter int WAIT_RETRIES = 3,
  parameter bit CHECK_ID     = 1'b1,
  parameter logic [31:0] EXPECT_ID = 32'h1BA01477
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobeT    stb,
  input  logic [31:0] rspRdata,
  output logic        rawBit,
  output logic        rawLast,
  output logic        retryLeft,
  output logic        idMatch,
  output logic [31:0] idCode,
  output logic [31:0] apId
);

  localparam int MAX_A  = (RESET_BITS > 16) ? RESET_BITS : 16;
  localparam int MAXLEN = (MAX_A > IDLE_BITS) ? MAX_A : IDLE_BITS;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int RTRY_W = $clog2(WAIT_RETRIES + 2);

  logic [CNT_W-1:0]  bitCnt;
  logic [15:0]       word;
  logic              fill;
  logic [RTRY_W-1:0] retryCnt;
  logic [31:0]       idReg;
  logic [31:0]       apReg;

  // raw pattern shifter: one bit per cycle, LSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      word   <= '0;
      fill   <= 1'b0;
    end else if (stb.load) begin
      case (stb.pat)
        PAT_RESET: begin
          bitCnt <= CNT_W'(RESET_BITS - 1);
          word   <= '1;
          fill   <= 1'b1;
        end
        PAT_SWITCH: begin
          bitCnt <= CNT_W'(15);
          word   <= SWITCH_WORD;
          fill   <= 1'b0;
        end
        default: begin
          bitCnt <= CNT_W'(IDLE_BITS - 1);
          word   <= '0;
          fill   <= 1'b0;
        end
      endcase
    end else if (stb.shift) begin
      bitCnt <= bitCnt - 1'b1;
      word   <= {fill, word[15:1]};
    end
  end

  assign rawBit  = word[0];
  assign rawLast = (bitCnt == '0);

  // per-step WAIT retry counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryCnt <= '0;
    end else if (stb.clrRetry) begin
      retryCnt <= '0;
    end else if (stb.incRetry) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  assign retryLeft = (retryCnt < RTRY_W'(WAIT_RETRIES));

  // captured identification values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg <= '0;
      apReg <= '0;
    end else if (stb.clrCaps) begin
      idReg <= '0;
      apReg <= '0;
    end else begin
      if (stb.capId) idReg <= rspRdata;
      if (stb.capAp) apReg <= rspRdata;
    end
  end

  assign idCode = idReg;
  assign apId   = apReg;

  generate
    if (CHECK_ID) begin : gIdCheck
      assign idMatch = (rspRdata == EXPECT_ID);
    end else begin : gIdAny
      assign idMatch = 1'b1;
    end
  endgenerate

  assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RTRY_W'(WAIT_RETRIES));

  assert_shift_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.load && fill) |=> rawBit);

endmodule

// File: rtl/swdc_ctrl.sv
module swdc_ctrl
  import swdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  apSel,
  input  logic        rawLast,
  input  logic        retryLeft,
  input  logic        idMatch,
  input  logic        rspValid,
  input  logic [2:0]  rspAck,
  input  logic        rspParityErr,
  output dpStrobeT    stb,
  output logic        rawEn,
  output logic        reqValid,
  output logic        reqApNDp,
  output logic        reqRnW,
  output logic [1:0]  reqAddr,
  output logic [31:0] reqWdata,
  output logic        busy,
  output logic        connected,
  output logic        failed,
  output logic [4:0]  errCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_RST1, S_SWITCH, S_RST2, S_GAP, S_XFER, S_RETRY
  } stateE;

  stateE      state, stateNext;
  stepE       step;
  logic       advance, failNow, finish;
  logic [1:0] failCause;

  always_comb begin
    stb       = '0;
    stb.pat   = PAT_RESET;
    stateNext = state;
    advance   = 1'b0;
    failNow   = 1'b0;
    failCause = CAUSE_ACK;
    finish    = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        stb.load     = 1'b1;
        stb.pat      = PAT_RESET;
        stb.clrCaps  = 1'b1;
        stb.clrRetry = 1'b1;
        stateNext    = S_RST1;
      end
      S_RST1: begin
        stb.shift = 1'b1;
        if (rawLast) begin
          stb.load  = 1'b1;
          stb.pat   = PAT_SWITCH;
          stateNext = S_SWITCH;
        end
      end
      S_SWITCH: begin
        stb.shift = 1'b1;
        if (rawLast) begin
          stb.load  = 1'b1;
          stb.pat   = PAT_RESET;
          stateNext = S_RST2;
        end
      end
      S_RST2: begin
        stb.shift = 1'b1;
        if (rawLast) begin
          stb.load  = 1'b1;
          stb.pat   = PAT_IDLE;
          stateNext = S_GAP;
        end
      end
      S_GAP: begin
        stb.shift = 1'b1;
        if (rawLast) stateNext = S_XFER;
      end
      S_XFER: if (rspValid) begin
        if (rspAck == ACK_OK) begin
          if (reqRnW && rspParityErr) begin
            failNow   = 1'b1;
            failCause = CAUSE_PARITY;
          end else if (step == STEP_ID && !idMatch) begin
            failNow   = 1'b1;
            failCause = CAUSE_IDMISS;
          end else begin
            advance      = 1'b1;
            stb.clrRetry = 1'b1;
            stb.capId    = (step == STEP_ID);
            stb.capAp    = (step == STEP_BUF);
            finish       = (step == STEP_BUF);
            stateNext    = finish ? S_IDLE : S_XFER;
          end
        end else if (rspAck == ACK_WAIT) begin
          if (retryLeft) begin
            stb.incRetry = 1'b1;
            stateNext    = S_RETRY;
          end else begin
            failNow   = 1'b1;
            failCause = CAUSE_WAIT;
          end
        end else begin
          failNow   = 1'b1;
          failCause = CAUSE_ACK;
        end
        if (failNow) stateNext = S_IDLE;
      end
      S_RETRY: stateNext = S_XFER;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      step      <= STEP_NONE;
      connected <= 1'b0;
      failed    <= 1'b0;
      errCode   <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) begin
        step      <= STEP_ID;
        connected <= 1'b0;
        failed    <= 1'b0;
        errCode   <= '0;
      end
      if (advance && !finish) step <= stepE'(step + 3'd1);
      if (finish) connected <= 1'b1;
      if (failNow) begin
        failed  <= 1'b1;
        errCode <= {step, failCause};
      end
    end
  end

  assign rawEn    = (state == S_RST1) || (state == S_SWITCH) ||
                    (state == S_RST2) || (state == S_GAP);
  assign reqValid = (state == S_XFER);
  assign busy     = (state != S_IDLE);

  always_comb begin
    reqApNDp = 1'b0;
    reqRnW   = 1'b1;
    reqAddr  = 2'd0;
    reqWdata = '0;
    case (step)
      STEP_SEL: begin
        reqRnW   = 1'b0;
        reqAddr  = 2'd2;
        reqWdata = {apSel, 16'h0000, 8'hF0};
      end
      STEP_APRD: begin
        reqApNDp = 1'b1;
        reqAddr  = 2'd3;
      end
      STEP_BUF: reqAddr = 2'd3;
      default: ;
    endcase
  end

  assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspValid) |=> (reqValid && $stable(reqAddr) &&
                                 $stable(reqRnW) && $stable(reqApNDp)));

  assert_handoff_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rawEn) |-> reqValid);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(connected && failed));

  assert_quiet_after_fail_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failed) |-> (!reqValid && !rawEn));

  assert_connect_on_resp_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(connected) |-> $past(rspValid));

endmodule

// File: rtl/swdc_connect.sv
module swdc_connect
  import swdc_pkg::*;
#(
  parameter int RESET_BITS   = 52,
  parameter int IDLE_BITS    = 2,
  parameter int WAIT_RETRIES = 3,
  parameter bit CHECK_ID     = 1'b1,
  parameter logic [31:0] EXPECT_ID = 32'h1BA01477
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  apSel,
  output logic        rawEn,
  output logic        rawBit,
  output logic        reqValid,
  output logic        reqApNDp,
  output logic        reqRnW,
  output logic [1:0]  reqAddr,
  output logic [31:0] reqWdata,
  input  logic        rspValid,
  input  logic [2:0]  rspAck,
  input  logic [31:0] rspRdata,
  input  logic        rspParityErr,
  output logic        busy,
  output logic        connected,
  output logic        failed,
  output logic [4:0]  errCode,
  output logic [31:0] idCode,
  output logic [31:0] apId
);

  dpStrobeT stb;
  logic     rawLast, retryLeft, idMatch;

  swdc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .apSel(apSel),
    .rawLast(rawLast), .retryLeft(retryLeft), .idMatch(idMatch),
    .rspValid(rspValid), .rspAck(rspAck), .rspParityErr(rspParityErr),
    .stb(stb), .rawEn(rawEn), .reqValid(reqValid), .reqApNDp(reqApNDp),
    .reqRnW(reqRnW), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .connected(connected), .failed(failed), .errCode(errCode)
  );

  swdc_datapath #(
    .RESET_BITS(RESET_BITS), .IDLE_BITS(IDLE_BITS),
    .WAIT_RETRIES(WAIT_RETRIES), .CHECK_ID(CHECK_ID), .EXPECT_ID(EXPECT_ID)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rspRdata(rspRdata),
    .rawBit(rawBit), .rawLast(rawLast), .retryLeft(retryLeft),
    .idMatch(idMatch), .idCode(idCode), .apId(apId)
  );

endmodule

// File: tb/tb_swdc_connect.sv
module tb_swdc_connect;

  localparam int RB = 52;
  localparam int IB = 2;
  localparam int WR = 2;
  localparam logic [31:0] EXP_ID = 32'h1BA01477;
  localparam logic [7:0]  AP_SEL = 8'h00;
  localparam int RAW_LEN = 2 * RB + 16 + IB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  apSel = AP_SEL;
  logic        rawEn, rawBit, reqValid, reqApNDp, reqRnW;
  logic [1:0]  reqAddr;
  logic [31:0] reqWdata;
  logic        rspValid = 1'b0;
  logic [2:0]  rspAck = 3'b000;
  logic [31:0] rspRdata = '0;
  logic        rspParityErr = 1'b0;
  logic        busy, connected, failed;
  logic [4:0]  errCode;
  logic [31:0] idCode, apId;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  swdc_connect #(
    .RESET_BITS(RB), .IDLE_BITS(IB), .WAIT_RETRIES(WR),
    .CHECK_ID(1'b1), .EXPECT_ID(EXP_ID)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .apSel(apSel),
    .rawEn(rawEn), .rawBit(rawBit), .reqValid(reqValid),
    .reqApNDp(reqApNDp), .reqRnW(reqRnW), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspAck(rspAck),
    .rspRdata(rspRdata), .rspParityErr(rspParityErr), .busy(busy),
    .connected(connected), .failed(failed), .errCode(errCode),
    .idCode(idCode), .apId(apId)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected<150000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {waitStep(7=all), nWaits, faultStep, parStep, badId, expConn, expErr}
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 4'd0, 3'd0, 3'd0, 1'b0, 1'b1, 5'b00000},  // clean
    {3'd1, 4'd2, 3'd0, 3'd0, 1'b0, 1'b1, 5'b00000},  // R6 waits within limit
    {3'd3, 4'd3, 3'd0, 3'd0, 1'b0, 1'b0, 5'b01101},  // R7 waits exhausted step 3
    {3'd0, 4'd0, 3'd2, 3'd0, 1'b0, 1'b0, 5'b01000},  // R8 fault at step 2
    {3'd0, 4'd0, 3'd0, 3'd4, 1'b0, 1'b0, 5'b10010},  // R9 parity at step 4
    {3'd0, 4'd0, 3'd0, 3'd0, 1'b1, 1'b0, 5'b00111},  // R10 id mismatch
    {3'd0, 4'd0, 3'd0, 3'd2, 1'b0, 1'b1, 5'b00000},  // R10 parity on write ignored
    {3'd7, 4'd2, 3'd0, 3'd0, 1'b0, 1'b1, 5'b00000},  // R6 retry count per step
    {3'd0, 4'd0, 3'd1, 3'd0, 1'b0, 1'b0, 5'b00100}   // R8 fault at step 1
  };

  function automatic string tagOf(input int idx);
    case (idx)
      1, 7: return "R6";
      2: return "R7";
      3, 8: return "R8";
      4: return "R9";
      5, 6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic runScen(input logic [19:0] v, input int idx, input bit midStart);
    logic [2:0] waitStep, faultStep, parStep;
    logic [3:0] nWaits;
    logic badId, expConn;
    logic [4:0] expErr;
    bit rb [RAW_LEN + 8];
    int n;
    bit okR2, okR4, okFields;
    logic [15:0] sw;
    int reqIdx, waitsGiven, hold, guard;
    {waitStep, nWaits, faultStep, parStep, badId, expConn, expErr} = v;

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!connected && !failed && errCode == 0 && idCode == 0 && apId == 0 && busy,
        "R11", "start clears results", {connected, failed, errCode}, 0);

    n = 0;
    while (rawEn && n < RAW_LEN + 8) begin
      rb[n] = rawBit;
      n++;
      start = (midStart && n == 10);
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == RAW_LEN, midStart ? "R12" : "R4", "raw phase length", n, RAW_LEN);
    okR2 = 1'b1;
    for (int i = 0; i < RB; i++) if (!rb[i]) okR2 = 1'b0;
    chk(okR2, "R2", "first reset bits all ones", okR2, 1);
    for (int i = 0; i < 16; i++) sw[i] = rb[RB + i];
    chk(sw == 16'hE79E, "R3", "switch word LSB first", sw, 16'hE79E);
    okR4 = 1'b1;
    for (int i = 0; i < RB; i++) if (!rb[RB + 16 + i]) okR4 = 1'b0;
    for (int i = 0; i < IB; i++) if (rb[2 * RB + 16 + i]) okR4 = 1'b0;
    chk(okR4 && reqValid && !rawEn, "R4", "second reset, idle zeros, handoff",
        {okR4, reqValid, rawEn}, 3'b110);

    reqIdx = 0; waitsGiven = 0; hold = 0; guard = 0; okFields = 1'b1;
    while (busy && guard < 2000) begin
      guard++;
      rspValid = 1'b0;
      if (reqValid) begin
        hold++;
        if (hold == 2) begin
          int st;
          st = reqIdx + 1;
          case (st)
            1: if (!(reqApNDp == 0 && reqRnW == 1 && reqAddr == 0)) okFields = 1'b0;
            2: if (!(reqApNDp == 0 && reqRnW == 0 && reqAddr == 2 &&
                     reqWdata == {AP_SEL, 16'h0000, 8'hF0})) okFields = 1'b0;
            3: if (!(reqApNDp == 1 && reqRnW == 1 && reqAddr == 3)) okFields = 1'b0;
            default: if (!(reqApNDp == 0 && reqRnW == 1 && reqAddr == 3)) okFields = 1'b0;
          endcase
          rspParityErr = 1'b0;
          rspRdata = '0;
          if ((waitStep == st[2:0] || waitStep == 3'd7) && waitsGiven < int'(nWaits)) begin
            rspAck = 3'b010;
            waitsGiven++;
          end else if (faultStep == st[2:0]) begin
            rspAck = 3'b100;
          end else begin
            rspAck = 3'b001;
            rspParityErr = (parStep == st[2:0]);
            case (st)
              1: rspRdata = badId ? 32'h12345678 : EXP_ID;
              3: rspRdata = 32'hDEAD0000 | idx;
              4: rspRdata = 32'h14770011 + idx;
              default: rspRdata = '0;
            endcase
            reqIdx++;
            waitsGiven = 0;
          end
          rspValid = 1'b1;
          hold = 0;
        end
      end else begin
        hold = 0;
      end
      @(negedge clk);
    end
    rspValid = 1'b0;
    chk(!busy, "R5", "sequence finished", busy, 0);
    chk(okFields, "R5", "request fields per step", okFields, 1);
    chk(connected == expConn && failed == !expConn && errCode == expErr,
        tagOf(idx), "outcome {connected,failed,errCode}",
        {connected, failed, errCode}, {expConn, !expConn, expErr});
    if (expConn) begin
      chk(idCode == EXP_ID && apId == 32'h14770011 + idx, "R11", "captured values",
          {idCode, apId}, {EXP_ID, 32'h14770011 + idx});
    end else begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 4; i++) begin
        if (reqValid || rawEn) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R8", "no activity after failure", quiet, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !connected && !failed && !rawEn && !reqValid && errCode == 0 &&
        idCode == 0 && apId == 0, "R1", "reset state",
        {busy, connected, failed, rawEn, reqValid, errCode}, 0);

    for (int k = 0; k < NV; k++) begin
      runScen(VEC[k], k, 1'b0);
      repeat (3) @(negedge clk);
    end

    // R11 hold after success
    runScen(VEC[0], 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(connected && idCode == EXP_ID && apId == 32'h14770011, "R11",
        "values held while idle", {connected, idCode}, {1'b1, EXP_ID});

    // R12 start pulse during a run is ignored
    runScen(VEC[0], 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule